// File: doc/BRIEF.md
# TCK Burst Counter

This block sets how many test-clock pulses reach local scan ports that are held in a parked state. A typical use is a built-in self-test that must run for an exact number of cycles. Software first selects the counter into the active scan chain and shifts in a start value. It then issues the enable instruction. From the next clock after Update-IR, the counter decrements once per rising edge. While the count is non-zero, the parked ports keep receiving clock. When the count reaches zero, their clock is gated off. This override holds until the disable instruction is issued.

The counter is a serial shift register whose least significant bit comes out first on the serial output. Instructions arrive as decoded strobes and take effect on the edge where Update-IR is active. When the counter is not enabled, the clock-enable for parked ports follows a control bit supplied from outside the block. A status flag reports terminal count. A sticky error flag records any attempt to unpark the ports while the count sits at zero.

Top module: `tck_burst_counter`

## Requirements
- R1: While `sel_cnt` and `shift_dr` are both high, each rising `tck` moves `tdi` into the most significant bit and moves the count right by one. `tdo_cnt` always shows bit 0, so a word loaded least significant bit first shifts back out in the same order.
- R2: A rising edge with `update_ir` and `ins_on` high, and `ins_off` low, enables the counter. The count does not change on that edge. On each later edge while enabled and not shifting, the count drops by one.
- R3: An enabled count of zero stays at zero. It never wraps.
- R4: While enabled with a count of zero, `park_tck_en` is low and `tc_flag` is high.
- R5: While enabled with a non-zero count, `park_tck_en` is high whatever `mode_tck_en` is.
- R6: While not enabled, `park_tck_en` equals `mode_tck_en` and `tc_flag` is low.
- R7: A rising edge with `update_ir` and `ins_off` high disables the counter. `ins_off` wins over `ins_on`. The count keeps the value it has after that edge, which is the last decrement, and it can be read out by shifting.
- R8: `unpark_req` high on an edge while `tc_flag` is high sets `unpark_err` from the next edge on. The flag stays set until a disable edge or reset clears it. `unpark_req` at any other time leaves `unpark_err` low.
- R9: `trst_n` low clears the count to zero, disables the counter and clears `unpark_err`, without waiting for a clock edge.
- R10: Shifting takes priority over decrementing. An enabled counter that is being shifted does not decrement on those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state updates on its rising edge |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial data entering the count register |
| shift_dr | input | 1 | TAP is in the data-shift state |
| update_ir | input | 1 | TAP is in the instruction-update state |
| sel_cnt | input | 1 | Decoded instruction: counter is in the scan chain |
| ins_on | input | 1 | Decoded instruction: enable counting |
| ins_off | input | 1 | Decoded instruction: disable counting |
| mode_tck_en | input | 1 | Parked-port clock control used while the counter is disabled |
| unpark_req | input | 1 | Request to release parked ports |
| tdo_cnt | output | 1 | Serial output, count bit 0 |
| park_tck_en | output | 1 | Clock enable for parked local ports |
| tc_flag | output | 1 | Enabled and at terminal count |
| unpark_err | output | 1 | Sticky flag: unpark requested at terminal count |

## Verification
A wrong count has no immediate effect at the ports. It shows when `park_tck_en` falls too early or too late, on the edge where the bad value should have reached or left zero. It also shows when the word is shifted out after a disable, within one register length of clocks. A stuck or wrongly set enable state shows at once, because `park_tck_en` then follows the mode bit when it should not, or the reverse. A wrong error flag shows one edge after the offending request, or on the disable edge that should have cleared it.

// File: rtl/tckc_pkg.sv
package tckc_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SHIFT = 2'd1,
    ACT_DEC   = 2'd2
  } cnt_act_e;

  // Shift beats decrement; decrement stops at zero.
  function automatic cnt_act_e pick_act(input logic shift_en, input logic run,
                                        input logic at_zero);
    if (shift_en)             return ACT_SHIFT;
    else if (run && !at_zero) return ACT_DEC;
    else                      return ACT_HOLD;
  endfunction

  // Counter, when enabled, owns the parked-port clock.
  function automatic logic gate_en(input logic run, input logic at_zero,
                                   input logic mode_bit);
    return run ? !at_zero : mode_bit;
  endfunction

endpackage

// File: rtl/tckc_shreg.sv
module tckc_shreg
  import tckc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic run,
  input  logic tdi,
  output logic at_zero_o,
  output logic tdo_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt;
  cnt_act_e     act;

  assign at_zero_o = (cnt == '0);
  assign tdo_o     = cnt[0];

  always_comb act = pick_act(shift_en, run, at_zero_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      case (act)
        ACT_SHIFT: cnt <= {tdi, cnt[W-1:1]};
        ACT_DEC:   cnt <= cnt - ONE;
        default:   cnt <= cnt;
      endcase
    end
  end

  assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (cnt[W-1] == $past(tdi)));

  assert_shift_prio_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && run) |=> (cnt[W-2:0] == $past(cnt[W-1:1])));

  assert_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !shift_en && !at_zero_o) |=> (cnt == $past(cnt) - ONE));

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !shift_en && at_zero_o) |=> at_zero_o);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !shift_en) |=> $stable(cnt));

endmodule

// File: rtl/tckc_ctrl.sv
module tckc_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_ir,
  input  logic ins_on,
  input  logic ins_off,
  input  logic unpark_req,
  input  logic at_zero,
  output logic run_o,
  output logic err_o
);
  logic on_evt, off_evt, bad_unpark;

  assign off_evt    = upd_ir && ins_off;
  assign on_evt     = upd_ir && ins_on && !ins_off;
  assign bad_unpark = run_o && at_zero && unpark_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o <= 1'b0;
    end else if (off_evt) begin
      run_o <= 1'b0;
    end else if (on_evt) begin
      run_o <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_o <= 1'b0;
    end else if (off_evt) begin
      err_o <= 1'b0;
    end else if (bad_unpark) begin
      err_o <= 1'b1;
    end
  end

  assert_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    on_evt |=> run_o);

  assert_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    off_evt |=> (!run_o && !err_o));

  assert_err_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_unpark && !off_evt) |=> err_o);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !off_evt) |=> err_o);

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(bad_unpark));

endmodule

// File: rtl/tck_burst_counter.sv
module tck_burst_counter
  import tckc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tdi,
  input  logic shift_dr,
  input  logic update_ir,
  input  logic sel_cnt,
  input  logic ins_on,
  input  logic ins_off,
  input  logic mode_tck_en,
  input  logic unpark_req,
  output logic tdo_cnt,
  output logic park_tck_en,
  output logic tc_flag,
  output logic unpark_err
);
  logic shift_en;
  logic run;
  logic at_zero;

  assign shift_en = sel_cnt && shift_dr;

  tckc_shreg #(.W(CNT_W)) u_shreg (
    .clk       (tck),
    .rst_n     (trst_n),
    .shift_en  (shift_en),
    .run       (run),
    .tdi       (tdi),
    .at_zero_o (at_zero),
    .tdo_o     (tdo_cnt)
  );

  tckc_ctrl u_ctrl (
    .clk        (tck),
    .rst_n      (trst_n),
    .upd_ir     (update_ir),
    .ins_on     (ins_on),
    .ins_off    (ins_off),
    .unpark_req (unpark_req),
    .at_zero    (at_zero),
    .run_o      (run),
    .err_o      (unpark_err)
  );

  assign tc_flag     = run && at_zero;
  assign park_tck_en = gate_en(run, at_zero, mode_tck_en);

  assert_gate_low_R4: assert property (@(posedge tck) disable iff (!trst_n)
    tc_flag |-> !park_tck_en);

  assert_override_R5: assert property (@(posedge tck) disable iff (!trst_n)
    (run && !tc_flag) |-> park_tck_en);

  assert_follow_mode_R6: assert property (@(posedge tck) disable iff (!trst_n)
    !run |-> (park_tck_en == mode_tck_en && !tc_flag));

  assert_reset_R9: assert property (@(posedge tck)
    !trst_n |-> (!tc_flag && !unpark_err && !tdo_cnt));

endmodule

// File: tb/test_tck_burst_counter.sv
module test_tck_burst_counter;
  localparam int W = 32;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tdi = 1'b0, shift_dr = 1'b0, update_ir = 1'b0, sel_cnt = 1'b0;
  logic ins_on = 1'b0, ins_off = 1'b0, mode_tck_en = 1'b0, unpark_req = 1'b0;
  logic tdo_cnt, park_tck_en, tc_flag, unpark_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 tck = ~tck;

  tck_burst_counter #(.CNT_W(W)) i_tck_burst_counter (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .shift_dr(shift_dr),
    .update_ir(update_ir), .sel_cnt(sel_cnt), .ins_on(ins_on),
    .ins_off(ins_off), .mode_tck_en(mode_tck_en), .unpark_req(unpark_req),
    .tdo_cnt(tdo_cnt), .park_tck_en(park_tck_en), .tc_flag(tc_flag),
    .unpark_err(unpark_err)
  );

  always @(posedge tck) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act %0d exp below 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck);
    @(negedge tck);
  endtask

  // Shift W bits LSB first; returns the word that was in the register.
  task automatic shift_word(input logic [W-1:0] din, output logic [W-1:0] dout);
    sel_cnt = 1'b1; shift_dr = 1'b1;
    for (int i = 0; i < W; i++) begin
      dout[i] = tdo_cnt;
      tdi = din[i];
      tick();
    end
    sel_cnt = 1'b0; shift_dr = 1'b0; tdi = 1'b0;
  endtask

  task automatic issue_on();
    update_ir = 1'b1; ins_on = 1'b1; tick(); update_ir = 1'b0; ins_on = 1'b0;
  endtask

  task automatic issue_off();
    update_ir = 1'b1; ins_off = 1'b1; tick(); update_ir = 1'b0; ins_off = 1'b0;
  endtask

  function automatic logic [W-1:0] sat_sub(input logic [W-1:0] a, input int b);
    return (a > W'(b)) ? a - W'(b) : '0;
  endfunction

  logic [W-1:0] got;

  initial begin
    @(negedge tck);
    // R9: reset state
    chk("R9 tc_flag in reset", W'(tc_flag), '0);
    chk("R9 err in reset", W'(unpark_err), '0);
    chk("R6 park follows mode in reset", W'(park_tck_en), W'(mode_tck_en));
    tick();
    trst_n = 1'b1;
    tick();
    shift_word('0, got);
    chk("R9 count zero after reset", got, '0);

    // R1: load and read back a pattern
    shift_word(32'hA5C3_0F1E, got);
    shift_word(32'h0000_0000, got);
    chk("R1 readback pattern", got, 32'hA5C3_0F1E);
    shift_word('0, got);
    chk("R1 second readback", got, '0);

    // R2..R7 sweep of start count, run length and mode bit
    for (int n = 0; n <= 6; n++) begin
      for (int k = 0; k <= 8; k++) begin
        logic m;
        m = logic'((n + k) % 2);
        mode_tck_en = m;
        shift_word(W'(n), got);
        issue_on();
        repeat (k) tick();
        chk("R4/R5 gate after k edges", W'(park_tck_en), W'(n > k));
        chk("R4 tc_flag after k edges", W'(tc_flag), W'(n <= k));
        issue_off();
        chk("R6 gate after off", W'(park_tck_en), W'(m));
        chk("R6 tc_flag after off", W'(tc_flag), '0);
        shift_word('0, got);
        chk("R2/R3/R7 residual count", got, sat_sub(W'(n), k + 1));
      end
    end

    // R10: shifting while enabled does not decrement
    mode_tck_en = 1'b0;
    shift_word(W'(100), got);
    issue_on();
    shift_word(W'(5), got);
    chk("R10 old value during run shift", got, W'(100));
    issue_off();
    shift_word('0, got);
    chk("R10 count after run shift", got, W'(4));

    // R3: large start value
    shift_word(32'hFFFF_FFFF, got);
    issue_on();
    repeat (10) tick();
    issue_off();
    shift_word('0, got);
    chk("R2 large count", got, 32'hFFFF_FFF4);

    // R8: unpark error
    unpark_req = 1'b1; tick(); unpark_req = 1'b0;
    chk("R8 no err when idle", W'(unpark_err), '0);
    shift_word(W'(3), got);
    issue_on();
    unpark_req = 1'b1; tick(); unpark_req = 1'b0;
    chk("R8 no err before tc", W'(unpark_err), '0);
    repeat (3) tick();
    chk("R4 at tc", W'(tc_flag), 1);
    unpark_req = 1'b1; tick(); unpark_req = 1'b0;
    chk("R8 err set", W'(unpark_err), 1);
    repeat (4) tick();
    chk("R8 err sticky", W'(unpark_err), 1);
    chk("R3 still zero", W'(tc_flag), 1);
    issue_off();
    chk("R8 err cleared by off", W'(unpark_err), '0);

    // R7: off wins over on
    shift_word(W'(9), got);
    update_ir = 1'b1; ins_on = 1'b1; ins_off = 1'b1; tick();
    update_ir = 1'b0; ins_on = 1'b0; ins_off = 1'b0;
    mode_tck_en = 1'b1;
    tick();
    chk("R7 off wins, gate follows mode", W'(park_tck_en), 1);
    shift_word('0, got);
    chk("R7 count untouched", got, W'(9));

    // R9: asynchronous reset mid-run
    mode_tck_en = 1'b0;
    shift_word(W'(50), got);
    issue_on();
    repeat (3) tick();
    #2 trst_n = 1'b0;
    #1;
    chk("R9 async gate", W'(park_tck_en), '0);
    chk("R9 async tc", W'(tc_flag), '0);
    @(negedge tck);
    trst_n = 1'b1;
    tick();
    shift_word('0, got);
    chk("R9 count cleared", got, '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule